// File: doc/BRIEF.md
# Single-Precision Minimum/Maximum Selector

This block is a purely combinational selector that works on raw IEEE-754 single-precision bit patterns. It takes two operands and a select line. It returns either the numerically larger or the numerically smaller operand. It does this without a floating-point comparator: ordering is decided on the sign-magnitude encoding.

Two cases get special treatment.

- **Ties.** When the two operands are numerically equal, max returns the bitwise AND of the patterns and min returns the bitwise OR. This rule also covers positive and negative zero, so the choice between them is deterministic.
- **NaN operands.** A NaN operand is skipped in favour of the other operand. When both operands are NaN, the result is the single canonical NaN pattern. A signaling NaN on either input raises an invalid-operation flag in the same cycle as the result.

Three helper outputs are derived from the first operand, for use by neighbouring datapath logic:

- its biased exponent field;
- the infinity that carries its sign;
- the value one that carries its sign.

Top module: `fminmax_sp`

## Requirements
- R1: With `sel_max`=1 and neither operand NaN nor equal, `result` is the operand with the larger value under sign-magnitude ordering. Any negative value is below any positive value. Among negatives, a larger magnitude is smaller. Infinities (exponent 0xFF, mantissa 0) order as the extremes.
- R2: With `sel_max`=0 and neither operand NaN nor equal, `result` is the operand with the smaller value.
- R3: When the operands are numerically equal, `result` is `op_a & op_b` for max and `op_a | op_b` for min. Numerically equal means identical patterns, or both zero with either sign. So max(+0,−0)=0x00000000 and min(+0,−0)=0x80000000.
- R4: When exactly one operand is NaN, `result` is the other operand unchanged, for both min and max. A NaN has exponent bits 30:23 all ones and a nonzero mantissa in bits 22:0.
- R5: When both operands are NaN, `result` is 0xFFFFFFFF. The block never outputs any other NaN pattern.
- R6: `invalid` is 1 exactly when at least one operand is a signaling NaN, that is a NaN with mantissa bit 22 equal to 0. Quiet NaNs (bit 22 = 1), infinities and ordinary numbers leave it 0.
- R7: `a_exp` equals bits 30:23 of `op_a`. Bias 127 applies, and 254 is the largest finite code.
- R8: `a_signed_inf` is `op_a` bit 31 placed in bit 31 of 0x7F800000.
- R9: `a_signed_one` is `op_a` bit 31 placed in bit 31 of 0x3F800000 (1.0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand bit pattern |
| op_b | input | 32 | Second operand bit pattern |
| sel_max | input | 1 | 1 selects maximum, 0 selects minimum |
| result | output | 32 | Selected value or canonical NaN |
| invalid | output | 1 | Signaling NaN seen on either input |
| a_exp | output | 8 | Biased exponent field of op_a |
| a_signed_inf | output | 32 | Infinity with the sign of op_a |
| a_signed_one | output | 32 | 1.0 with the sign of op_a |

## Verification
The assertions hold on every evaluation, for any input pattern. They check four things:

- an output NaN is always canonical;
- a single NaN operand always yields the other operand;
- a non-NaN pair never raises `invalid`;
- identical inputs return themselves, and the helper outputs keep their fixed exponent and mantissa bits.

Only the bench scenarios can show which operand wins an ordered comparison. That covers negatives against positives, infinities, and the resolution of the signed-zero tie. The bench also checks that quiet NaNs stay silent while signaling NaNs in either operand position raise the flag.

// File: rtl/fminmax_sp.sv
module fminmax_sp #(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 23,
  localparam int W     = 1 + EXP_W + MANT_W
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic             sel_max,
  output logic [W-1:0]     result,
  output logic             invalid,
  output logic [EXP_W-1:0] a_exp,
  output logic [W-1:0]     a_signed_inf,
  output logic [W-1:0]     a_signed_one
);
  localparam logic [W-1:0] CANON_NAN = '1;
  localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W - 1)) - 1);

  logic             sa, sb;
  logic [W-2:0]     ma, mb;
  logic             a_nan, b_nan, a_snan, b_snan;
  logic             both_zero, tie, a_less;
  logic [W-1:0]     larger, smaller;

  assign sa = op_a[W-1];
  assign sb = op_b[W-1];
  assign ma = op_a[W-2:0];
  assign mb = op_b[W-2:0];

  assign a_nan  = (&op_a[W-2:MANT_W]) && (|op_a[MANT_W-1:0]);
  assign b_nan  = (&op_b[W-2:MANT_W]) && (|op_b[MANT_W-1:0]);
  assign a_snan = a_nan && !op_a[MANT_W-1];
  assign b_snan = b_nan && !op_b[MANT_W-1];
  assign invalid = a_snan | b_snan;

  assign both_zero = (ma == '0) && (mb == '0);
  assign tie       = both_zero || (op_a == op_b);

  always_comb begin
    if (sa != sb) a_less = sa;
    else if (!sa) a_less = ma < mb;
    else          a_less = ma > mb;
  end

  assign larger  = a_less ? op_b : op_a;
  assign smaller = a_less ? op_a : op_b;

  always_comb begin
    if (a_nan && b_nan) result = CANON_NAN;
    else if (a_nan)     result = op_b;
    else if (b_nan)     result = op_a;
    else if (tie)       result = sel_max ? (op_a & op_b) : (op_a | op_b);
    else                result = sel_max ? larger : smaller;
  end

  assign a_exp        = op_a[W-2:MANT_W];
  assign a_signed_inf = {sa, {EXP_W{1'b1}}, {MANT_W{1'b0}}};
  assign a_signed_one = {sa, 1'b0, BIAS[EXP_W-2:0], {MANT_W{1'b0}}};
endmodule

module fminmax_sp_chk #(
  parameter int EXP_W  = 8,
  parameter int MANT_W = 23,
  localparam int W     = 1 + EXP_W + MANT_W
) (
  input logic [W-1:0]     op_a,
  input logic [W-1:0]     op_b,
  input logic             sel_max,
  input logic [W-1:0]     result,
  input logic             invalid,
  input logic [EXP_W-1:0] a_exp,
  input logic [W-1:0]     a_signed_inf,
  input logic [W-1:0]     a_signed_one
);
  logic an, bn, rn;
  assign an = (&op_a[W-2:MANT_W]) && (|op_a[MANT_W-1:0]);
  assign bn = (&op_b[W-2:MANT_W]) && (|op_b[MANT_W-1:0]);
  assign rn = (&result[W-2:MANT_W]) && (|result[MANT_W-1:0]);

  always_comb begin
    AST_NAN_CANON: assert (!rn || result == '1); // R5
    AST_ONE_NAN_A: assert (!(an && !bn) || result == op_b); // R4
    AST_ONE_NAN_B: assert (!(bn && !an) || result == op_a); // R4
    AST_NO_NAN_QUIET: assert (an || bn || !invalid); // R6
    AST_SAME_SELF: assert (an || op_a != op_b || result == op_a); // R3
    AST_PICK_INPUT: assert (an || bn || sel_max || result == op_a || result == op_b || result == (op_a | op_b)); // R2
    AST_INF_SHAPE: assert (&a_signed_inf[W-2:MANT_W] && a_signed_inf[MANT_W-1:0] == '0 && a_signed_inf[W-1] == op_a[W-1]); // R8
    AST_ONE_SHAPE: assert (a_signed_one[MANT_W-1:0] == '0 && a_signed_one[W-1] == op_a[W-1] && !a_signed_one[W-2]); // R9
    AST_EXP_RANGE: assert (a_exp != '1 || an || op_a[MANT_W-1:0] == '0); // R7
  end
endmodule

bind fminmax_sp fminmax_sp_chk #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_chk (
  .op_a(op_a), .op_b(op_b), .sel_max(sel_max), .result(result),
  .invalid(invalid), .a_exp(a_exp), .a_signed_inf(a_signed_inf),
  .a_signed_one(a_signed_one)
);

// File: tb/tb_fminmax_sp.sv
module tb_fminmax_sp;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic sel_max = 1'b0;
  logic [31:0] result, a_signed_inf, a_signed_one;
  logic invalid;
  logic [7:0] a_exp;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fminmax_sp dut (
    .op_a(op_a), .op_b(op_b), .sel_max(sel_max), .result(result),
    .invalid(invalid), .a_exp(a_exp), .a_signed_inf(a_signed_inf),
    .a_signed_one(a_signed_one)
  );

  // {sel_max, op_a, op_b, expected result, expected invalid}
  localparam logic [97:0] VEC [NV] = '{
    {1'b1, 32'h3F800000, 32'h40000000, 32'h40000000, 1'b0}, // R1 pos
    {1'b0, 32'h3F800000, 32'h40000000, 32'h3F800000, 1'b0}, // R2 pos
    {1'b1, 32'hBF800000, 32'hC0000000, 32'hBF800000, 1'b0}, // R1 neg
    {1'b0, 32'hBF800000, 32'hC0000000, 32'hC0000000, 1'b0}, // R2 neg
    {1'b1, 32'hBF800000, 32'h3F000000, 32'h3F000000, 1'b0}, // R1 mixed
    {1'b0, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0}, // R3 min zeros
    {1'b1, 32'h00000000, 32'h80000000, 32'h00000000, 1'b0}, // R3 max zeros
    {1'b1, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0}, // R3 swapped
    {1'b1, 32'h40A00000, 32'h40A00000, 32'h40A00000, 1'b0}, // R3 equal
    {1'b1, 32'h7FC00000, 32'h3F800000, 32'h3F800000, 1'b0}, // R4 qnan a
    {1'b0, 32'h3F800000, 32'h7F800001, 32'h3F800000, 1'b1}, // R4 R6 snan b
    {1'b1, 32'h7FC00000, 32'hFFC00000, 32'hFFFFFFFF, 1'b0}, // R5 two qnan
    {1'b0, 32'hFF800005, 32'h7FC00000, 32'hFFFFFFFF, 1'b1}, // R5 R6 snan a
    {1'b1, 32'h7F800000, 32'h7F7FFFFF, 32'h7F800000, 1'b0}, // R1 inf
    {1'b0, 32'hFF800000, 32'hBF800000, 32'hFF800000, 1'b0}, // R2 -inf
    {1'b0, 32'h7F800000, 32'hFF800000, 32'hFF800000, 1'b0}  // R2 infs, R6 quiet
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R3 reset zeros", result, 32'h0);
    chk("R6 reset flag", {31'b0, invalid}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      {sel_max, op_a, op_b} = VEC[i][97:33];
      @(negedge clk);
      chk("R1/R2/R3/R4/R5 result", result, VEC[i][32:1]);
      chk("R6 invalid", {31'b0, invalid}, {31'b0, VEC[i][0]});
      chk("R7 exponent", {24'b0, a_exp}, {24'b0, op_a[30:23]});
      chk("R8 signed inf", a_signed_inf, op_a[31] ? 32'hFF800000 : 32'h7F800000);
      chk("R9 signed one", a_signed_one, op_a[31] ? 32'hBF800000 : 32'h3F800000);
    end
    @(posedge clk);
    op_a = 32'h7F7FFFFF; op_b = 32'h7F800000; sel_max = 1'b0;
    @(negedge clk);
    chk("R7 max finite exp", {24'b0, a_exp}, 32'd254);
    chk("R2 finite below inf", result, 32'h7F7FFFFF);
    @(posedge clk);
    op_a = 32'h7FA00000; op_b = 32'hFF800001; sel_max = 1'b1;
    @(negedge clk);
    chk("R6 two snan flag", {31'b0, invalid}, 32'h1);
    chk("R5 two snan result", result, 32'hFFFFFFFF);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule